// File: doc/BRIEF.md
# Cache Line Poison Tracker

This block keeps one poison flag per line of a small unified write-back cache and applies the poison rules to every access that touches a line. Line fills arrive from the bus fill buffer as a fixed number of sub-line beats. Each beat carries a double-bit ECC error indication and a hard-error-response indication. The block collects the beats and writes the line only when the last beat arrives. If any beat carried an error, the whole line is marked poisoned at that point. No chunk is recalled or repaired.

Core loads, fetches and stores arrive on a request port with a valid/ready handshake, one per cycle. A read of a poisoned line raises a machine-check pulse for the local core instead of returning data. A store to a poisoned line is discarded. Snoops and evictions copy the whole line into a write-back queue entry, with the poison flag carried as a sideband bit. Writing back a poisoned line also raises a corrected-machine-check interrupt pulse. Data always leaves the block exactly as it was received; no reserved error pattern is substituted.

Top module: `line_poison_ctrl`

## Requirements
- R1: When a fill completes and any of its beats had `fill_dbe` set, the line becomes valid and poisoned. The data is still stored as received.
- R2: The poison decision is applied only at fill completion. Beats arrive in order 0 to BEATS-1, and the line is complete on the BEATS-th beat. Before completion the target line reads as a miss.
- R3: A beat with `fill_herr` set poisons the line in the same way as a double-bit error.
- R4: An accepted load (`req_op`=00) or fetch (`req_op`=01) to a valid poisoned line gives `mce_local` high for exactly the next cycle, with `rsp_valid` low. A read of a clean valid line gives `rsp_valid`=1, `rsp_hit`=1 and the addressed beat on `rsp_data` in the next cycle, with `mce_local` low.
- R5: An accepted store (`req_op`=10) to a poisoned line changes neither the line data nor its poison flag.
- R6: A snoop or eviction of a valid poisoned line produces a write-back entry with `wbq_poison`=1 and a one-cycle `cmci` pulse in the next cycle. A clean line gives `wbq_poison`=0 and no `cmci`.
- R7: `wbq_data` holds the line exactly as filled or stored. Beat b occupies bits [b*BEAT_W +: BEAT_W], for both poisoned and clean lines.
- R8: After reset all lines are invalid and unpoisoned. The first beat of a new fill invalidates the line and clears its old poison flag, and a clean refill leaves it unpoisoned.
- R9: A store to a clean valid line replaces only beat `req_beat`. A store to an invalid line is dropped.
- R10: `req_ready` is low in any cycle in which a fill completes or `wb_req_valid` is high. An eviction (`wb_req_snoop`=0) invalidates the line, and a snoop (`wb_req_snoop`=1) leaves it valid.
- R11: A snoop or eviction of an invalid line produces no write-back entry and no `cmci`. A read of an invalid line gives `rsp_valid`=1, `rsp_hit`=0 and `rsp_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_valid | input | 1 | A fill beat is present |
| fill_idx | input | $clog2(LINES) | Line receiving the fill |
| fill_data | input | BEAT_W | Beat payload |
| fill_dbe | input | 1 | Double-bit ECC error on this beat |
| fill_herr | input | 1 | Hard-error response on the transaction |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Core request can be accepted |
| req_op | input | 2 | 00 load, 01 fetch, 10 store |
| req_idx | input | $clog2(LINES) | Line addressed |
| req_beat | input | $clog2(BEATS) | Beat within the line |
| req_wdata | input | BEAT_W | Store data |
| rsp_valid | output | 1 | Read response pulse |
| rsp_hit | output | 1 | Response came from a valid line |
| rsp_data | output | BEAT_W | Returned beat |
| mce_local | output | 1 | Local machine-check pulse |
| wb_req_valid | input | 1 | Snoop or eviction request |
| wb_req_idx | input | $clog2(LINES) | Line to write back |
| wb_req_snoop | input | 1 | 1 snoop (line kept), 0 eviction |
| wbq_valid | output | 1 | Write-back queue entry pulse |
| wbq_idx | output | $clog2(LINES) | Line of the entry |
| wbq_data | output | LINE_W | Whole line, unchanged |
| wbq_poison | output | 1 | Sideband double-bit-error mark |
| cmci | output | 1 | Corrected-machine-check interrupt pulse |

## Verification
The assertions check several rules on every cycle. A read of a poisoned line must be followed by a machine-check pulse and no response. A write-back of a poisoned line must carry the sideband bit and the interrupt, and the interrupt never appears without a poisoned entry. A completed erroneous fill must leave the line poisoned, a first beat must clear the old flag, and a store that meets a poisoned line must leave it untouched. Only the bench scenarios show the rest. These are that the written-back data matches the received beats bit for bit, that an error on the first, middle or last beat gives the same result, that a line reads as a miss in the middle of a refill, and that eviction and snoop differ in whether the line survives.

// File: rtl/lpc_pkg.sv
package lpc_pkg;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_FETCH = 2'b01,
    OP_STORE = 2'b10,
    OP_RSVD  = 2'b11
  } core_op_e;

  // A beat taints its line if either error indication is present.
  function automatic logic beat_taints(input logic dbe, input logic herr);
    return dbe | herr;
  endfunction

  function automatic logic is_read_op(input core_op_e op);
    return (op == OP_LOAD) || (op == OP_FETCH);
  endfunction

endpackage

// File: rtl/lpc_fill_collect.sv
module lpc_fill_collect #(
  parameter int LINES  = 8,
  parameter int BEATS  = 4,
  parameter int BEAT_W = 32,
  localparam int IW     = (LINES > 1) ? $clog2(LINES) : 1,
  localparam int CW     = (BEATS > 1) ? $clog2(BEATS) : 1,
  localparam int LINE_W = BEATS * BEAT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_valid,
  input  logic [IW-1:0]     fill_idx,
  input  logic [BEAT_W-1:0] fill_data,
  input  logic              fill_dbe,
  input  logic              fill_herr,
  output logic              fill_start,
  output logic              fill_done,
  output logic [IW-1:0]     done_idx,
  output logic [LINE_W-1:0] done_data,
  output logic              done_poison
);
  import lpc_pkg::*;

  localparam logic [CW-1:0] LAST_BEAT = CW'(BEATS - 1);

  logic [CW-1:0]     beat_q;
  logic [LINE_W-1:0] buf_q;
  logic              taint_q;
  logic              beat_bad;

  assign beat_bad    = beat_taints(fill_dbe, fill_herr);
  assign fill_start  = fill_valid && (beat_q == '0);
  assign fill_done   = fill_valid && (beat_q == LAST_BEAT);
  assign done_idx    = fill_idx;
  // Decision only once every beat is in the buffer.
  assign done_poison = taint_q | beat_bad;

  always_comb begin
    done_data = buf_q;
    done_data[beat_q*BEAT_W +: BEAT_W] = fill_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q  <= '0;
      buf_q   <= '0;
      taint_q <= 1'b0;
    end else if (fill_valid) begin
      buf_q[beat_q*BEAT_W +: BEAT_W] <= fill_data;
      if (fill_done) begin
        beat_q  <= '0;
        taint_q <= 1'b0;
      end else begin
        beat_q  <= beat_q + 1'b1;
        taint_q <= taint_q | beat_bad;
      end
    end
  end

endmodule

// File: rtl/lpc_line_array.sv
module lpc_line_array #(
  parameter int LINES  = 8,
  parameter int BEATS  = 4,
  parameter int BEAT_W = 32,
  localparam int IW     = (LINES > 1) ? $clog2(LINES) : 1,
  localparam int CW     = (BEATS > 1) ? $clog2(BEATS) : 1,
  localparam int LINE_W = BEATS * BEAT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_start,
  input  logic              fill_done,
  input  logic [IW-1:0]     fill_idx,
  input  logic [LINE_W-1:0] fill_data,
  input  logic              fill_poison,
  input  logic              st_en,
  input  logic              st_try,
  input  logic [IW-1:0]     st_idx,
  input  logic [CW-1:0]     st_beat,
  input  logic [BEAT_W-1:0] st_data,
  input  logic              inv_en,
  input  logic [IW-1:0]     inv_idx,
  input  logic [IW-1:0]     a_idx,
  output logic              a_valid,
  output logic              a_poison,
  output logic [LINE_W-1:0] a_data,
  input  logic [IW-1:0]     b_idx,
  output logic              b_valid,
  output logic              b_poison,
  output logic [LINE_W-1:0] b_data
);

  logic [LINES-1:0]  valid_all;
  logic [LINES-1:0]  pois_all;
  logic [LINE_W-1:0] data_all [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic              v_q;
    logic              p_q;
    logic [LINE_W-1:0] d_q;
    logic              hit_fill, hit_start, hit_inv, hit_st, hit_try;

    assign hit_fill  = fill_done  && (fill_idx == IW'(i));
    assign hit_start = fill_start && (fill_idx == IW'(i));
    assign hit_inv   = inv_en     && (inv_idx  == IW'(i));
    assign hit_st    = st_en      && (st_idx   == IW'(i));
    assign hit_try   = st_try     && (st_idx   == IW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        p_q <= 1'b0;
        d_q <= '0;
      end else if (hit_fill) begin
        v_q <= 1'b1;
        p_q <= fill_poison;
        d_q <= fill_data;
      end else if (hit_start || hit_inv) begin
        v_q <= 1'b0;
        p_q <= 1'b0;
      end else if (hit_st) begin
        d_q[st_beat*BEAT_W +: BEAT_W] <= st_data;
      end
    end

    assign valid_all[i] = v_q;
    assign pois_all[i]  = p_q;
    assign data_all[i]  = d_q;

    AST_FILL_SETS_POISON: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_fill && fill_poison) |=> (v_q && p_q)); // R1
    AST_FILL_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_start && !hit_fill) |=> (!v_q && !p_q)); // R8
    AST_STORE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_try && p_q && !hit_fill && !hit_start && !hit_inv) |=> ($stable(d_q) && p_q)); // R5
  end

  assign a_valid  = valid_all[a_idx];
  assign a_poison = pois_all[a_idx];
  assign a_data   = data_all[a_idx];
  assign b_valid  = valid_all[b_idx];
  assign b_poison = pois_all[b_idx];
  assign b_data   = data_all[b_idx];

endmodule

// File: rtl/lpc_access.sv
module lpc_access #(
  parameter int LINES  = 8,
  parameter int BEATS  = 4,
  parameter int BEAT_W = 32,
  localparam int IW     = (LINES > 1) ? $clog2(LINES) : 1,
  localparam int CW     = (BEATS > 1) ? $clog2(BEATS) : 1,
  localparam int LINE_W = BEATS * BEAT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_done,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [CW-1:0]     req_beat,
  input  logic              a_valid,
  input  logic              a_poison,
  input  logic [LINE_W-1:0] a_data,
  output logic              st_en,
  output logic              st_try,
  input  logic              wb_req_valid,
  input  logic [IW-1:0]     wb_req_idx,
  input  logic              wb_req_snoop,
  input  logic              b_valid,
  input  logic              b_poison,
  input  logic [LINE_W-1:0] b_data,
  output logic              inv_en,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [BEAT_W-1:0] rsp_data,
  output logic              mce_local,
  output logic              wbq_valid,
  output logic [IW-1:0]     wbq_idx,
  output logic [LINE_W-1:0] wbq_data,
  output logic              wbq_poison,
  output logic              cmci
);
  import lpc_pkg::*;

  function automatic logic [BEAT_W-1:0] pick_beat(input logic [LINE_W-1:0] line,
                                                  input logic [CW-1:0] b);
    return line[b*BEAT_W +: BEAT_W];
  endfunction

  core_op_e op;
  logic     accept, rd_acc, rd_bad, wb_fire;

  assign op        = core_op_e'(req_op);
  assign req_ready = !fill_done && !wb_req_valid;
  assign accept    = req_valid && req_ready;
  assign rd_acc    = accept && is_read_op(op);
  assign rd_bad    = rd_acc && a_valid && a_poison;
  assign st_try    = accept && (op == OP_STORE);
  assign st_en     = st_try && a_valid && !a_poison;
  assign wb_fire   = wb_req_valid && b_valid;
  assign inv_en    = wb_fire && !wb_req_snoop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_data   <= '0;
      mce_local  <= 1'b0;
      wbq_valid  <= 1'b0;
      wbq_idx    <= '0;
      wbq_data   <= '0;
      wbq_poison <= 1'b0;
      cmci       <= 1'b0;
    end else begin
      rsp_valid  <= rd_acc && !rd_bad;
      rsp_hit    <= rd_acc && a_valid && !a_poison;
      rsp_data   <= (rd_acc && a_valid && !a_poison) ? pick_beat(a_data, req_beat) : '0;
      mce_local  <= rd_bad;
      wbq_valid  <= wb_fire;
      wbq_idx    <= wb_req_idx;
      wbq_data   <= wb_fire ? b_data : '0;
      wbq_poison <= wb_fire && b_poison;
      cmci       <= wb_fire && b_poison;
    end
  end

  AST_POISON_READ_MCE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && is_read_op(op) && a_valid && a_poison) |=> (mce_local && !rsp_valid)); // R4
  AST_CLEAN_READ_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && is_read_op(op) && !(a_valid && a_poison)) |=> (rsp_valid && !mce_local)); // R4
  AST_WB_POISON_CMCI: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req_valid && b_valid && b_poison) |=> (wbq_valid && wbq_poison && cmci)); // R6
  AST_CMCI_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    cmci |-> (wbq_valid && wbq_poison)); // R6
  AST_NO_BLIND_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req_valid && !b_valid) |=> (!wbq_valid && !cmci)); // R11

endmodule

// File: rtl/line_poison_ctrl.sv
module line_poison_ctrl #(
  parameter int LINES  = 8,
  parameter int BEATS  = 4,
  parameter int BEAT_W = 32,
  localparam int IW     = (LINES > 1) ? $clog2(LINES) : 1,
  localparam int CW     = (BEATS > 1) ? $clog2(BEATS) : 1,
  localparam int LINE_W = BEATS * BEAT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_valid,
  input  logic [IW-1:0]     fill_idx,
  input  logic [BEAT_W-1:0] fill_data,
  input  logic              fill_dbe,
  input  logic              fill_herr,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [IW-1:0]     req_idx,
  input  logic [CW-1:0]     req_beat,
  input  logic [BEAT_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [BEAT_W-1:0] rsp_data,
  output logic              mce_local,
  input  logic              wb_req_valid,
  input  logic [IW-1:0]     wb_req_idx,
  input  logic              wb_req_snoop,
  output logic              wbq_valid,
  output logic [IW-1:0]     wbq_idx,
  output logic [LINE_W-1:0] wbq_data,
  output logic              wbq_poison,
  output logic              cmci
);

  logic              fill_start, fill_done, done_poison;
  logic [IW-1:0]     done_idx;
  logic [LINE_W-1:0] done_data;
  logic              st_en, st_try, inv_en;
  logic              a_valid, a_poison, b_valid, b_poison;
  logic [LINE_W-1:0] a_data, b_data;

  lpc_fill_collect #(.LINES(LINES), .BEATS(BEATS), .BEAT_W(BEAT_W)) u_fill (
    .clk(clk), .rst_n(rst_n),
    .fill_valid(fill_valid), .fill_idx(fill_idx), .fill_data(fill_data),
    .fill_dbe(fill_dbe), .fill_herr(fill_herr),
    .fill_start(fill_start), .fill_done(fill_done), .done_idx(done_idx),
    .done_data(done_data), .done_poison(done_poison)
  );

  lpc_line_array #(.LINES(LINES), .BEATS(BEATS), .BEAT_W(BEAT_W)) u_array (
    .clk(clk), .rst_n(rst_n),
    .fill_start(fill_start), .fill_done(fill_done), .fill_idx(done_idx),
    .fill_data(done_data), .fill_poison(done_poison),
    .st_en(st_en), .st_try(st_try), .st_idx(req_idx), .st_beat(req_beat), .st_data(req_wdata),
    .inv_en(inv_en), .inv_idx(wb_req_idx),
    .a_idx(req_idx), .a_valid(a_valid), .a_poison(a_poison), .a_data(a_data),
    .b_idx(wb_req_idx), .b_valid(b_valid), .b_poison(b_poison), .b_data(b_data)
  );

  lpc_access #(.LINES(LINES), .BEATS(BEATS), .BEAT_W(BEAT_W)) u_access (
    .clk(clk), .rst_n(rst_n), .fill_done(fill_done),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op), .req_beat(req_beat),
    .a_valid(a_valid), .a_poison(a_poison), .a_data(a_data),
    .st_en(st_en), .st_try(st_try),
    .wb_req_valid(wb_req_valid), .wb_req_idx(wb_req_idx), .wb_req_snoop(wb_req_snoop),
    .b_valid(b_valid), .b_poison(b_poison), .b_data(b_data), .inv_en(inv_en),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data), .mce_local(mce_local),
    .wbq_valid(wbq_valid), .wbq_idx(wbq_idx), .wbq_data(wbq_data),
    .wbq_poison(wbq_poison), .cmci(cmci)
  );

endmodule

// File: tb/line_poison_ctrl_bench.sv
module line_poison_ctrl_bench;

  localparam int LINES = 8, BEATS = 4, BEAT_W = 32, IW = 3, CW = 2, LINE_W = 128;
  localparam int NV = 6;
  localparam logic [IW-1:0] T_IDX  [NV] = '{3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6};
  localparam logic [3:0]    T_DBE  [NV] = '{4'b0000, 4'b0001, 4'b1000, 4'b0000, 4'b0010, 4'b0000};
  localparam logic [3:0]    T_HERR [NV] = '{4'b0000, 4'b0000, 4'b0000, 4'b0100, 4'b0010, 4'b0000};

  logic clk = 0, rst_n = 0;
  logic fill_valid = 0, fill_dbe = 0, fill_herr = 0;
  logic [IW-1:0] fill_idx = '0;
  logic [BEAT_W-1:0] fill_data = '0;
  logic req_valid = 0, req_ready;
  logic [1:0] req_op = 2'b00;
  logic [IW-1:0] req_idx = '0;
  logic [CW-1:0] req_beat = '0;
  logic [BEAT_W-1:0] req_wdata = '0;
  logic rsp_valid, rsp_hit, mce_local;
  logic [BEAT_W-1:0] rsp_data;
  logic wb_req_valid = 0, wb_req_snoop = 0;
  logic [IW-1:0] wb_req_idx = '0;
  logic wbq_valid, wbq_poison, cmci;
  logic [IW-1:0] wbq_idx;
  logic [LINE_W-1:0] wbq_data;

  int checks = 0, errors = 0;
  logic [LINE_W-1:0] expl;

  always #10 clk = ~clk;

  line_poison_ctrl u_line_poison_ctrl (.*);

  function automatic logic [BEAT_W-1:0] beat_val(input int e, input int b);
    return 32'hC0DE_0000 | (e << 8) | b;
  endfunction

  function automatic logic [LINE_W-1:0] line_val(input int e);
    logic [LINE_W-1:0] l;
    for (int b = 0; b < BEATS; b++) l[b*BEAT_W +: BEAT_W] = beat_val(e, b);
    return l;
  endfunction

  task automatic chk(input string tag, input logic [LINE_W-1:0] act, input logic [LINE_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic fill_beat(input int idx, input int b, input int e, input bit dbe, input bit herr);
    fill_valid = 1; fill_idx = IW'(idx); fill_data = beat_val(e, b);
    fill_dbe = dbe; fill_herr = herr;
    @(negedge clk);
    fill_valid = 0; fill_dbe = 0; fill_herr = 0;
  endtask

  task automatic fill_line(input int idx, input int e, input logic [3:0] dbe, input logic [3:0] herr);
    for (int b = 0; b < BEATS; b++) fill_beat(idx, b, e, dbe[b], herr[b]);
  endtask

  task automatic core(input logic [1:0] op, input int idx, input int b, input logic [BEAT_W-1:0] wd);
    req_valid = 1; req_op = op; req_idx = IW'(idx); req_beat = CW'(b); req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wb(input int idx, input bit snoop);
    wb_req_valid = 1; wb_req_idx = IW'(idx); wb_req_snoop = snoop;
    @(negedge clk);
    wb_req_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // Reset state R8
    chk("R8 reset ready", req_ready, 1);
    chk("R8 reset outputs", {rsp_valid, mce_local, wbq_valid, cmci}, 0);
    core(2'b00, 0, 0, 0);
    chk("R11 miss rsp", {rsp_valid, rsp_hit, mce_local}, 3'b100);
    chk("R11 miss data", rsp_data, 0);
    wb(0, 1);
    chk("R11 invalid wb", {wbq_valid, cmci}, 0);

    // Vector table: fill, read, snoop
    for (int e = 0; e < NV; e++) begin
      logic pois;
      pois = (|T_DBE[e]) | (|T_HERR[e]);
      fill_line(T_IDX[e], e, T_DBE[e], T_HERR[e]);
      core((e % 2 == 0) ? 2'b00 : 2'b01, T_IDX[e], e % BEATS, 0);
      if (pois) begin
        chk("R4 poisoned read", {mce_local, rsp_valid}, 2'b10);
        @(negedge clk);
        chk("R4 mce pulse", mce_local, 0);
      end else begin
        chk("R4 clean read", {mce_local, rsp_valid, rsp_hit}, 3'b011);
        chk("R4 clean data", rsp_data, beat_val(e, e % BEATS));
      end
      wb(T_IDX[e], 1);
      chk("R1 R3 R6 wb poison", {wbq_valid, wbq_poison, cmci}, {1'b1, pois, pois});
      chk("R7 wb data", wbq_data, line_val(e));
      chk("R7 wb idx", wbq_idx, T_IDX[e]);
      @(negedge clk);
      chk("R6 cmci pulse", cmci, 0);
    end

    // R10 snoop keeps line 1
    core(2'b00, 1, 3, 0);
    chk("R10 snoop keeps", {rsp_valid, rsp_hit}, 2'b11);

    // R9 store to clean line 1 beat 2
    core(2'b10, 1, 2, 32'h1234_5678);
    wb(1, 1);
    expl = line_val(0); expl[2*BEAT_W +: BEAT_W] = 32'h1234_5678;
    chk("R9 store beat", wbq_data, expl);
    core(2'b10, 0, 0, 32'hDEAD_BEEF);
    core(2'b00, 0, 0, 0);
    chk("R9 store invalid dropped", {rsp_valid, rsp_hit}, 2'b10);

    // R5 store to poisoned line 2
    core(2'b10, 2, 0, 32'hFFFF_0000);
    wb(2, 1);
    chk("R5 poisoned data kept", wbq_data, line_val(1));
    chk("R5 poison kept", wbq_poison, 1);
    core(2'b01, 2, 1, 0);
    chk("R5 still mce", mce_local, 1);

    // R2/R8 refill line 2 clean, read mid-fill
    fill_beat(2, 0, 9, 0, 0);
    fill_beat(2, 1, 9, 0, 0);
    core(2'b00, 2, 0, 0);
    chk("R2 mid-fill miss", {rsp_valid, rsp_hit, mce_local}, 3'b100);
    fill_beat(2, 2, 9, 0, 0);
    // R10 ready low on completing beat
    fill_valid = 1; fill_idx = 3'd2; fill_data = beat_val(9, 3);
    #1 chk("R10 ready low on fill done", req_ready, 0);
    @(negedge clk);
    fill_valid = 0;
    wb(2, 1);
    chk("R8 refill clean", {wbq_valid, wbq_poison, cmci}, 3'b100);
    chk("R7 refill data", wbq_data, line_val(9));

    // R10 ready low with wb request; eviction invalidates poisoned line 3
    wb_req_valid = 1; wb_req_idx = 3'd3; wb_req_snoop = 0;
    #1 chk("R10 ready low on wb", req_ready, 0);
    @(negedge clk);
    wb_req_valid = 0;
    chk("R6 evict poisoned", {wbq_valid, wbq_poison, cmci}, 3'b111);
    core(2'b00, 3, 0, 0);
    chk("R10 evict invalidates", {rsp_valid, rsp_hit, mce_local}, 3'b100);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule